// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits beside an 8-bit microcontroller core and decides which clocks run. Software asks for a light sleep or a deep sleep through two request bits of a power-control register. In light sleep (idle) the CPU clock stops while timers, the serial port, interrupt logic and RAM stay clocked. In deep sleep (power-down) the oscillator is switched off. The block also turns the raw reset pin into a qualified internal reset. It blocks RAM writes while a reset is taking hold. It supplies the levels that the address-latch and program-store strobes and the low address/data port must show while the core sleeps.

Idle ends on an enabled pending interrupt or on the reset pin. When the reset pin ends idle, the CPU clock restarts at once. The core may execute for up to two machine cycles before the qualified reset lands. In that window RAM writes are inhibited and port writes are not. Power-down ends only on the reset pin. The oscillator is re-enabled and internal reset is held for a parameterised stabilisation count.

Top module: `lpm_ctrl`

## Requirements
- R1: In idle, `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` are 1, and the mode holds until an exit condition occurs.
- R2: In idle, `irq_pend` high with the synchronised reset low returns the block to run on the next clock: `cpu_clk_en` is 1 one cycle after `irq_pend` is applied.
- R3: In power-down, `osc_en`, `cpu_clk_en` and `per_clk_en` are all 0, and `irq_pend` has no effect on them.
- R4: When `pdown_req` and `idle_req` are both high in run, power-down is entered, not idle.
- R5: The reset pin passes a two-flop synchroniser, then must stay high for QUAL_MC×OSC_PER_MC clocks (24 by default). `rst_int` rises 26 clocks after the pin is first sampled high. A shorter pulse never raises `rst_int`.
- R6: The reset pin ends idle three clocks after it is sampled high. From then until `rst_int` rises, `cpu_clk_en` and `ram_wr_inhibit` are both 1. If the pin drops early, the block returns to run three clocks after the drop.
- R7: The reset pin leaves power-down three clocks after it is sampled high. `osc_en` and `rst_int` are then 1, and both clock enables are 0, for exactly STAB_CNT clocks. After that the block runs and `rst_int` follows the qualified pin.
- R8: `strobe_force` is 1 in either low-power mode. `ale_lvl` and `psen_lvl` are 1 in idle and 0 in power-down.
- R9: `p0_float` is 1 only in a low-power mode with `ext_code` high; it follows `ext_code` with no delay.
- R10: Under power-on reset the outputs show run with no internal reset. `rst_int` falls three clocks after the pin falls, and `ram_wr_inhibit` is 1 while `rst_int` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, active low |
| rst_pin | input | 1 | Raw external reset pin, active high |
| idle_req | input | 1 | Idle request bit from the power-control register |
| pdown_req | input | 1 | Power-down request bit from the power-control register |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_code | input | 1 | Core executes from external program memory |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral, interrupt and RAM clock enable |
| osc_en | output | 1 | Oscillator enable |
| rst_int | output | 1 | Qualified internal reset |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| strobe_force | output | 1 | Strobes and Port 0 driven by this block |
| ale_lvl | output | 1 | Address-latch strobe level while forced |
| psen_lvl | output | 1 | Program-store strobe level while forced |
| p0_float | output | 1 | Port 0 released to high impedance |

## Verification
The hardest case to reach is the short window in which a reset pin has already ended idle but has not yet been qualified. The CPU clock is running, RAM writes are blocked, and `rst_int` is still low. The stimulus enters idle through a one-cycle request, then raises the pin and samples at the clocks just inside and outside that window. A second run drops the pin halfway through, so the early return to run without any internal reset is also seen.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int OSC_PER_MC = 12,
  parameter int QUAL_MC    = 2,
  parameter int STAB_CNT   = 1024
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  input  logic idle_req,
  input  logic pdown_req,
  input  logic irq_pend,
  input  logic ext_code,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic osc_en,
  output logic rst_int,
  output logic ram_wr_inhibit,
  output logic strobe_force,
  output logic ale_lvl,
  output logic psen_lvl,
  output logic p0_float
);

  localparam int QUAL = OSC_PER_MC * QUAL_MC;
  localparam int QW   = $clog2(QUAL + 1);
  localparam int SW   = $clog2(STAB_CNT + 1);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_PD, S_WIN, S_STAB} mode_t;

  mode_t          state, nstate;
  logic           rst_meta, rst_s;
  logic [QW-1:0]  qcnt;
  logic [SW-1:0]  scnt;
  logic           qual_done, stab_done;

  assign qual_done = (qcnt == QW'(QUAL));
  assign stab_done = (scnt == SW'(STAB_CNT - 1));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) {rst_s, rst_meta} <= 2'b00;
    else        {rst_s, rst_meta} <= {rst_meta, rst_pin};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                       qcnt <= '0;
    else if (!rst_s)                  qcnt <= '0;
    else if (state != S_PD && !qual_done) qcnt <= qcnt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)              scnt <= '0;
    else if (state != S_STAB) scnt <= '0;
    else if (!stab_done)     scnt <= scnt + 1'b1;

  always_comb begin
    nstate = state;
    case (state)
      S_RUN:  if (!rst_int) begin
                if (pdown_req)     nstate = S_PD;
                else if (idle_req) nstate = S_IDLE;
              end
      S_IDLE: if (rst_s)          nstate = S_WIN;
              else if (irq_pend)  nstate = S_RUN;
      S_PD:   if (rst_s)          nstate = S_STAB;
      S_WIN:  if (qual_done || !rst_s) nstate = S_RUN;
      S_STAB: if (stab_done)      nstate = S_RUN;
      default:                    nstate = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) state <= S_RUN;
    else        state <= nstate;

  assign rst_int        = qual_done || (state == S_STAB);
  assign cpu_clk_en     = (state == S_RUN) || (state == S_WIN);
  assign per_clk_en     = cpu_clk_en || (state == S_IDLE);
  assign osc_en         = (state != S_PD);
  assign ram_wr_inhibit = rst_int || (state == S_WIN);
  assign strobe_force   = (state == S_IDLE) || (state == S_PD);
  assign ale_lvl        = (state == S_IDLE);
  assign psen_lvl       = (state == S_IDLE);
  assign p0_float       = strobe_force && ext_code;

  p_idle_clk_r1: assert property (@(posedge clk) disable iff (!por_n)
    (strobe_force && osc_en) |-> (!cpu_clk_en && per_clk_en));

  p_irq_exit_r2: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_IDLE && irq_pend && !rst_s) |=> cpu_clk_en);

  p_pd_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
    (!osc_en && !rst_s) |=> (!osc_en && !per_clk_en));

  p_pd_prio_r4: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_RUN && !rst_int && pdown_req && idle_req) |=> !osc_en);

  p_qual_pin_r5: assert property (@(posedge clk) disable iff (!por_n)
    (rst_int && state != S_STAB) |-> $past(rst_s));

  p_window_r6: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_WIN) |-> (cpu_clk_en && ram_wr_inhibit));

  p_wake_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(osc_en) |-> (rst_int && !cpu_clk_en));

  p_strobe_lvl_r8: assert property (@(posedge clk) disable iff (!por_n)
    strobe_force |-> (ale_lvl == osc_en && psen_lvl == osc_en));

  p_float_r9: assert property (@(posedge clk) disable iff (!por_n)
    p0_float |-> (strobe_force && ext_code));

  p_ram_guard_r10: assert property (@(posedge clk) disable iff (!por_n)
    rst_int |-> ram_wr_inhibit);

endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  localparam int STAB = 40;
  // vector bits: cpu, per, osc, rst, inh, force, ale, psen, float
  localparam logic [8:0] V_RUN   = 9'b111000000;
  localparam logic [8:0] V_IDLE  = 9'b011001110;
  localparam logic [8:0] V_IDLEX = 9'b011001111;
  localparam logic [8:0] V_PD    = 9'b000001000;
  localparam logic [8:0] V_PDX   = 9'b000001001;
  localparam logic [8:0] V_WIN   = 9'b111010000;
  localparam logic [8:0] V_RST   = 9'b111110000;
  localparam logic [8:0] V_STAB  = 9'b001110000;

  logic clk = 0, por_n = 0, rst_pin = 0, idle_req = 0, pdown_req = 0, irq_pend = 0, ext_code = 0;
  logic cpu_clk_en, per_clk_en, osc_en, rst_int, ram_wr_inhibit, strobe_force, ale_lvl, psen_lvl, p0_float;
  int cyc = 0, nchk = 0, nfail = 0;
  bit done = 0;
  int     q_cyc[$];
  logic [8:0] q_val[$];
  string  q_tag[$];

  lpm_ctrl #(.STAB_CNT(STAB)) dut (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .idle_req(idle_req), .pdown_req(pdown_req),
    .irq_pend(irq_pend), .ext_code(ext_code), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .rst_int(rst_int), .ram_wr_inhibit(ram_wr_inhibit), .strobe_force(strobe_force),
    .ale_lvl(ale_lvl), .psen_lvl(psen_lvl), .p0_float(p0_float));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wire [8:0] obs = {cpu_clk_en, per_clk_en, osc_en, rst_int, ram_wr_inhibit,
                    strobe_force, ale_lvl, psen_lvl, p0_float};

  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      nchk++;
      if (q_cyc[0] < cyc) begin
        nfail++;
        $display("FAIL %s: sample for cycle %0d missed (now %0d), expected %b", q_tag[0], q_cyc[0], cyc, q_val[0]);
      end else if (obs !== q_val[0]) begin
        nfail++;
        $display("FAIL %s: cycle %0d actual %b expected %b", q_tag[0], cyc, obs, q_val[0]);
      end
      void'(q_cyc.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic want(int off, logic [8:0] v, string tag);
    q_cyc.push_back(cyc + off); q_val.push_back(v); q_tag.push_back(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    tick(3);
    want(0, V_RUN, "R10");                 // reset state
    tick(1);
    por_n = 1;
    tick(2);
    want(0, V_RUN, "R10");

    // idle entry, hold, float, interrupt exit
    idle_req = 1; want(1, V_IDLE, "R1"); want(1, V_IDLE, "R8");
    tick(1); idle_req = 0;
    want(3, V_IDLE, "R1");
    tick(4);
    ext_code = 1; want(0, V_IDLEX, "R9");
    tick(1);
    ext_code = 0; want(0, V_IDLE, "R9");
    tick(1);
    irq_pend = 1; want(0, V_IDLE, "R2"); want(1, V_RUN, "R2");
    tick(1); irq_pend = 0;
    ext_code = 1; want(0, V_RUN, "R9");
    tick(2); ext_code = 0;

    // both requests: power-down wins; interrupt ignored
    idle_req = 1; pdown_req = 1; want(1, V_PD, "R4"); want(1, V_PD, "R8");
    tick(1); idle_req = 0; pdown_req = 0;
    irq_pend = 1; want(3, V_PD, "R3");
    tick(4); irq_pend = 0;
    ext_code = 1; want(0, V_PDX, "R9");
    tick(1); ext_code = 0;
    // wake by reset pin
    rst_pin = 1;
    want(2, V_PD, "R7"); want(3, V_STAB, "R7");
    want(2 + STAB, V_STAB, "R7"); want(3 + STAB, V_RST, "R7");
    tick(STAB + 6);
    rst_pin = 0; want(2, V_RST, "R10"); want(3, V_RUN, "R10");
    tick(6);

    // short pulse filtered
    rst_pin = 1; tick(20); rst_pin = 0;
    want(0, V_RUN, "R5"); want(4, V_RUN, "R5"); want(8, V_RUN, "R5");
    tick(10);
    // full qualification
    rst_pin = 1; want(25, V_RUN, "R5"); want(26, V_RST, "R5");
    tick(30);
    idle_req = 1; want(1, V_RST, "R10");   // request ignored during reset
    tick(2); idle_req = 0;
    rst_pin = 0; want(3, V_RUN, "R10");
    tick(6);

    // reset ends idle: execution window
    idle_req = 1; want(1, V_IDLE, "R6");
    tick(1); idle_req = 0;
    tick(3);
    rst_pin = 1;
    want(2, V_IDLE, "R6"); want(3, V_WIN, "R6"); want(25, V_WIN, "R6"); want(26, V_RST, "R6");
    tick(30);
    rst_pin = 0; want(3, V_RUN, "R10");
    tick(6);
    // pin released early inside the window
    idle_req = 1; want(1, V_IDLE, "R6");
    tick(1); idle_req = 0;
    tick(2);
    rst_pin = 1; want(3, V_WIN, "R6");
    tick(5); rst_pin = 0;
    want(2, V_WIN, "R6"); want(3, V_RUN, "R6"); want(30, V_RUN, "R6");
    tick(34);
    finish_run();
  end

  initial begin
    #100000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule